// File: doc/BRIEF.md
# Share-Domain Class Selector

This unit picks the winning output class of a classifier whose confidence scores are never held as plain values. Each class score arrives as two signed arithmetic shares, and the true score is their sum. Classes are offered one at a time over a ready/valid handshake. The arrival position of a class (0 to 9 by default) is its index.

The unit keeps the shares and the index of the best class seen so far. For every later class it forms two cross differences: the candidate's first share minus the best's second share, and the candidate's second share minus the best's first share. No single difference ever holds both shares of one score. The sign of the sum of those two differences decides the comparison. That sign is found by a bit-serial ripple carry whose carry is stored masked under a fresh random bit in every step.

A comparison occupies the carry engine for several cycles, so the unit withholds `in_ready` until the decision is back. After the last class it pulses `done` and presents the winning index. That index then holds until the next `start`.

Top module: `masked_argmax`

## Requirements
- R1: After reset, `in_ready` is 0, `done` is 0 and `best_idx` is 0.
- R2: One cycle after `start` is sampled high, `in_ready` is 1. `start` may arrive in any state and restarts the run from class 0.
- R3: The first class of a run is stored as the best without a comparison, so `in_ready` is still 1 in the cycle after it is accepted.
- R4: After any later class is accepted, `in_ready` stays 0 until that class's comparison has finished. The next class is accepted only after that.
- R5: The reported index is the arrival position (0 = first accepted) of the class whose share sum `sh0 + sh1` is largest, and it is always below the class count.
- R6: When scores are equal, the later class wins, so the highest index among the equal maxima is reported.
- R7: `done` is high for exactly one cycle after the last class's decision, and `best_idx` carries the winner in that cycle. `in_ready` is 0 while `done` is high.
- R8: `best_idx` keeps its value after `done` until the next `start`. In the cycle after `start` it reads 0.
- R9: The result depends only on the share sums. Any other split of the same scores, and any random bit sequence, gives the same index.
- R10: Shares at the full signed range (-2048 and 2047 at the default 12-bit width) are compared without overflow, because differences are one bit wider than a share and the sum one bit wider again.
- R11: A `start` during a run, including while a comparison is in flight, discards all partial results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new selection run |
| in_valid | input | 1 | A class score is offered |
| in_ready | output | 1 | Unit can accept a class this cycle |
| in_sh0 | input | SHARE_W | First signed share of the offered score |
| in_sh1 | input | SHARE_W | Second signed share of the offered score |
| rnd_bit | input | 1 | Fresh random bit, consumed every cycle of a comparison |
| done | output | 1 | One-cycle strobe: winning index is valid |
| best_idx | output | IDX_W | Winning class index |

## Verification
The bench targets ties, the first-class path, full-range shares and aborted runs.

- A design that takes the tie the wrong way reports the lower index when equal maxima occur.
- A design that compares the first class against stale state reports an index from the previous run.
- One whose differences are too narrow mis-orders 4094 against -4096.
- One that ignores a mid-run restart keeps the large discarded scores as the winner.

Resplitting the same scores with different random streams would expose a sign decision that leaks or depends on the mask. Dropping `in_ready` too late would let a second class overrun a comparison still in flight.

// File: rtl/argmax_pkg.sv
package argmax_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCEPT = 2'd1,
        ST_WAIT   = 2'd2
    } am_state_e;

endpackage

// File: rtl/cross_diff.sv
module cross_diff #(
    parameter int SHARE_W = 12,
    localparam int DIFF_W = SHARE_W + 1
) (
    input  logic signed [SHARE_W-1:0] cand_sh0,
    input  logic signed [SHARE_W-1:0] cand_sh1,
    input  logic signed [SHARE_W-1:0] best_sh0,
    input  logic signed [SHARE_W-1:0] best_sh1,
    output logic signed [DIFF_W-1:0]  diff_a,
    output logic signed [DIFF_W-1:0]  diff_b
);
    logic signed [DIFF_W-1:0] c0_x, c1_x, b0_x, b1_x;

    always_comb begin
        c0_x   = {cand_sh0[SHARE_W-1], cand_sh0};
        c1_x   = {cand_sh1[SHARE_W-1], cand_sh1};
        b0_x   = {best_sh0[SHARE_W-1], best_sh0};
        b1_x   = {best_sh1[SHARE_W-1], best_sh1};
        // each term pairs shares of two different scores
        diff_a = c0_x - b1_x;
        diff_b = c1_x - b0_x;
    end
endmodule

// File: rtl/masked_sign_chain.sv
module masked_sign_chain #(
    parameter int DIFF_W = 13,
    localparam int CW    = DIFF_W + 1,
    localparam int CNT_W = $clog2(CW)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     go,
    input  logic signed [DIFF_W-1:0] diff_a,
    input  logic signed [DIFF_W-1:0] diff_b,
    input  logic                     rnd_bit,
    output logic                     busy,
    output logic                     res_valid,
    output logic                     sign_out
);
    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    x;
        logic [CW-1:0]    y;
        logic [CNT_W-1:0] cnt;
        logic             m;     // carry xor mask
        logic             r;     // mask
        logic             sign;
        logic             vld;
    } chain_t;

    chain_t q, d;
    logic   carry_plain;
    logic   carry_new;

    always_comb begin
        d           = q;
        d.vld       = 1'b0;
        carry_plain = q.m ^ q.r;
        carry_new   = (q.x[0] & q.y[0]) | (carry_plain & (q.x[0] ^ q.y[0]));
        if (flush) begin
            d.busy = 1'b0;
        end else if (go) begin
            d.busy = 1'b1;
            d.x    = {diff_a[DIFF_W-1], diff_a};
            d.y    = {diff_b[DIFF_W-1], diff_b};
            d.cnt  = '0;
            d.m    = rnd_bit;        // carry-in 0 under a fresh mask
            d.r    = rnd_bit;
        end else if (q.busy) begin
            if (q.cnt == CNT_W'(CW - 1)) begin
                d.sign = q.x[0] ^ q.y[0] ^ carry_plain;
                d.vld  = 1'b1;
                d.busy = 1'b0;
            end else begin
                d.m   = rnd_bit ^ carry_new;
                d.r   = rnd_bit;
                d.x   = q.x >> 1;
                d.y   = q.y >> 1;
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = q.busy;
    assign res_valid = q.vld;
    assign sign_out  = q.sign;
endmodule

// File: rtl/masked_argmax.sv
module masked_argmax
    import argmax_pkg::*;
#(
    parameter int SHARE_W     = 12,
    parameter int NUM_CLASSES = 10,
    localparam int IDX_W      = $clog2(NUM_CLASSES),
    localparam int DIFF_W     = SHARE_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic signed [SHARE_W-1:0] in_sh0,
    input  logic signed [SHARE_W-1:0] in_sh1,
    input  logic                      rnd_bit,
    output logic                      done,
    output logic [IDX_W-1:0]          best_idx
);
    typedef struct packed {
        am_state_e                 st;
        logic [IDX_W-1:0]          cnt;
        logic signed [SHARE_W-1:0] b0;
        logic signed [SHARE_W-1:0] b1;
        logic signed [SHARE_W-1:0] c0;
        logic signed [SHARE_W-1:0] c1;
        logic [IDX_W-1:0]          bidx;
        logic [IDX_W-1:0]          oidx;
        logic                      done;
    } ctl_t;

    ctl_t q, d;
    logic go;
    logic chain_busy, chain_res_valid, chain_sign;
    logic signed [DIFF_W-1:0] diff_a, diff_b;

    cross_diff #(.SHARE_W(SHARE_W)) diff_i (
        .cand_sh0 (in_sh0),
        .cand_sh1 (in_sh1),
        .best_sh0 (q.b0),
        .best_sh1 (q.b1),
        .diff_a   (diff_a),
        .diff_b   (diff_b)
    );

    masked_sign_chain #(.DIFF_W(DIFF_W)) chain_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (start),
        .go        (go),
        .diff_a    (diff_a),
        .diff_b    (diff_b),
        .rnd_bit   (rnd_bit),
        .busy      (chain_busy),
        .res_valid (chain_res_valid),
        .sign_out  (chain_sign)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        go     = 1'b0;
        if (start) begin
            d.st   = ST_ACCEPT;
            d.cnt  = '0;
            d.bidx = '0;
            d.oidx = '0;
        end else begin
            unique case (q.st)
                ST_ACCEPT: begin
                    if (in_valid) begin
                        if (q.cnt == '0) begin
                            d.b0   = in_sh0;
                            d.b1   = in_sh1;
                            d.bidx = '0;
                            d.cnt  = IDX_W'(1);
                        end else begin
                            d.c0 = in_sh0;
                            d.c1 = in_sh1;
                            go   = 1'b1;
                            d.st = ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (chain_res_valid) begin
                        // sign 0: candidate >= best, later class wins ties
                        if (!chain_sign) begin
                            d.b0   = q.c0;
                            d.b1   = q.c1;
                            d.bidx = q.cnt;
                        end
                        if (q.cnt == IDX_W'(NUM_CLASSES - 1)) begin
                            d.done = 1'b1;
                            d.oidx = chain_sign ? q.bidx : q.cnt;
                            d.st   = ST_IDLE;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                            d.st  = ST_ACCEPT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign in_ready = (q.st == ST_ACCEPT);
    assign done     = q.done;
    assign best_idx = q.oidx;
endmodule

// File: rtl/argmax_checker.sv
module argmax_checker #(
    parameter int NUM_CLASSES = 10,
    parameter int IDX_W       = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             in_ready,
    input logic             done,
    input logic [IDX_W-1:0] best_idx,
    input logic             chain_busy,
    input logic             chain_res_valid
);
    a_r4_busy_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        chain_busy |-> !in_ready);

    a_r4_result_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        chain_res_valid |-> $past(chain_busy));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (done || $stable(best_idx)));

    a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        best_idx < IDX_W'(NUM_CLASSES));
endmodule

bind masked_argmax argmax_checker #(.NUM_CLASSES(NUM_CLASSES), .IDX_W(IDX_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .in_ready        (in_ready),
    .done            (done),
    .best_idx        (best_idx),
    .chain_busy      (chain_busy),
    .chain_res_valid (chain_res_valid)
);

// File: tb/masked_argmax_tb_top.sv
module masked_argmax_tb_top;
    localparam int SW = 12;
    localparam int NC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [SW-1:0] in_sh0 = '0;
    logic signed [SW-1:0] in_sh1 = '0;
    logic rnd_bit = 1'b0;
    logic done;
    logic [3:0] best_idx;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int sc [NC];
    int s0 [NC];
    int s1 [NC];

    masked_argmax #(.SHARE_W(SW), .NUM_CLASSES(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_ready(in_ready), .in_sh0(in_sh0), .in_sh1(in_sh1),
        .rnd_bit(rnd_bit), .done(done), .best_idx(best_idx)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            rnd_bit = 1'($urandom);
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++; bad++;
                $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_best();
        int b = 0;
        for (int i = 1; i < NC; i++) if (sc[i] >= sc[b]) b = i;
        return b;
    endfunction

    // random split of each score into two in-range shares
    task automatic split_scores();
        for (int i = 0; i < NC; i++) begin
            s0[i] = int'($urandom_range(2047)) - 1024;
            s1[i] = sc[i] - s0[i];
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(in_ready == 1'b1, "R2 ready after start", int'(in_ready), 1);
    endtask

    task automatic feed_one(input int i);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_sh0 = SW'(s0[i]);
        in_sh1 = SW'(s1[i]);
        @(negedge clk);
        in_valid = 1'b0;
        if (i == 0) chk(in_ready == 1'b1, "R3 first class no compare", int'(in_ready), 1);
        else        chk(in_ready == 1'b0, "R4 ready low during compare", int'(in_ready), 0);
    endtask

    task automatic run_set(input string req);
        int exp_idx;
        bit seen;
        exp_idx = ref_best();
        pulse_start();
        for (int i = 0; i < NC; i++) feed_one(i);
        seen = 1'b0;
        for (int k = 0; k < 200 && !seen; k++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        chk(seen, "R7 done seen", int'(seen), 1);
        chk(best_idx == 4'(exp_idx), req, int'(best_idx), exp_idx);
        chk(in_ready == 1'b0, "R7 not ready at done", int'(in_ready), 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b0, "R1 reset ready", int'(in_ready), 0);
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        chk(best_idx == 4'd0, "R1 reset idx", int'(best_idx), 0);
    endtask

    task automatic t_patterns();
        for (int i = 0; i < NC; i++) sc[i] = 10 * i;          // rising
        split_scores(); run_set("R5 rising");
        for (int i = 0; i < NC; i++) sc[i] = 500 - 37 * i;    // falling
        split_scores(); run_set("R5 falling");
        for (int i = 0; i < NC; i++) sc[i] = -900 + i;
        sc[4] = 800;                                          // peak mid
        split_scores(); run_set("R5 middle peak");
        for (int i = 0; i < NC; i++) sc[i] = -1000 + 3 * i * i;
        sc[2] = -5;                                           // all negative
        split_scores(); run_set("R5 negatives");
    endtask

    task automatic t_ties();
        for (int i = 0; i < NC; i++) sc[i] = 100;
        split_scores(); run_set("R6 all equal");
        for (int i = 0; i < NC; i++) sc[i] = 0;
        sc[1] = 300; sc[6] = 300;
        split_scores(); run_set("R6 tie later wins");
    endtask

    task automatic t_resplit();
        for (int i = 0; i < NC; i++) sc[i] = (i * 7) % 5 * 50;
        sc[3] = 450; sc[8] = 449;
        for (int k = 0; k < 3; k++) begin
            split_scores(); run_set("R9 resplit");
        end
    endtask

    task automatic t_extreme();
        for (int i = 0; i < NC; i++) begin
            s0[i] = -2048; s1[i] = -2048;
        end
        s0[5] = 2047; s1[5] = 2047;
        s0[7] = 2047; s1[7] = -2048;
        for (int i = 0; i < NC; i++) sc[i] = s0[i] + s1[i];
        run_set("R10 full range max");
        for (int i = 0; i < NC; i++) begin
            s0[i] = 2047; s1[i] = 2047;
        end
        s0[0] = -2048; s1[0] = -2048;
        s0[9] = 2047;  s1[9] = 2046;
        for (int i = 0; i < NC; i++) sc[i] = s0[i] + s1[i];
        run_set("R10 full range late min");
    endtask

    task automatic t_hold();
        logic [3:0] held;
        held = best_idx;
        repeat (25) @(negedge clk);
        chk(best_idx == held, "R8 index holds", int'(best_idx), int'(held));
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(best_idx == 4'd0, "R8 start clears index", int'(best_idx), 0);
    endtask

    task automatic t_abort();
        for (int i = 0; i < NC; i++) begin
            s0[i] = 1500; s1[i] = 1500;
        end
        pulse_start();
        for (int i = 0; i < 4; i++) feed_one(i);
        // run_set restarts while the last comparison is still in flight
        for (int i = 0; i < NC; i++) sc[i] = 20 * ((i + 3) % NC);
        split_scores();
        run_set("R11 abort restarts");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_ties();
        t_resplit();
        t_extreme();
        t_hold();
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule